// File: doc/BRIEF.md
# Host Command/Reply Queue Port

This block is the device-side window through which a host exchanges messages with a storage controller core over a 32-bit register bus. The host hands over work by writing the bus address of a command structure into a request register. Each such write lands in an inbound queue, and the core drains that queue through a valid/ready handshake. The core reports finished work by pushing completion tags into an outbound queue, also through a valid/ready handshake. The host collects those tags by reading a reply register, and each read consumes one entry.

Beside the two queues the block holds four more registers. The first is a doorbell word that the core can see. The second is a status word that shows whether replies are waiting. The third is an interrupt mask with inverted polarity: setting the bit turns the interrupt off. The fourth is a readiness word that tells the host when the core's firmware is up. A level interrupt is raised while replies are waiting and the mask bit is clear. A parameter moves the mask bit and the reply-pending bit together to another bit position, so that the block can serve a second controller variant.

Top module: `cqp_port`

## Requirements
- R1: A bus write to offset 0x40 enqueues the written 32-bit word in the inbound queue. The core receives the words in write order: `core_cmd_valid` is high while the queue holds entries, `core_cmd_data` shows the oldest entry, and one entry leaves on each cycle where valid and ready are both high.
- R2: A bus read of offset 0x44 returns the oldest outbound completion and removes it. The read data appears on `bus_rdata` after the clock edge at which `bus_rd` was sampled high.
- R3: A read of offset 0x44 while the outbound queue is empty returns 0xFFFFFFFF and leaves the outbound queue unchanged.
- R4: The mask register at offset 0x34 keeps only bit MASK_BIT (3 by default, 2 in the variant). Writing a 1 to that bit disables the interrupt, and writing 0 enables it. After reset the bit is 1. A read of the register returns the bit in place, with all other bits 0.
- R5: A read of offset 0x30 returns bit MASK_BIT set exactly when the outbound queue is non-empty, whatever the mask holds. All other bits read 0.
- R6: `irq` is high exactly when the outbound queue is non-empty and the mask bit is clear. It is low from the first cycle after the read that removes the last entry.
- R7: A read of offset 0xB0 returns 0xFFFF0000 while `core_fw_ready` is high, and 0 otherwise.
- R8: A write to offset 0x40 while the inbound queue is full is dropped and does not alter the queue contents. It also sets `req_overflow`, which stays high until reset.
- R9: `core_cpl_ready` is low exactly when the outbound queue holds DEPTH entries. A completion offered while it is low is not stored.
- R10: After reset both queues are empty, `irq`, `core_cmd_valid` and `req_overflow` are low, and `core_cpl_ready` is high.
- R11: A write to offset 0x20 stores the word in the doorbell register. The stored word drives `core_doorbell` and reads back at that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| core_cmd_valid | output | 1 | Inbound queue holds a command address |
| core_cmd_ready | input | 1 | Core takes the head command |
| core_cmd_data | output | 32 | Oldest command address |
| core_cpl_valid | input | 1 | Core offers a completion tag |
| core_cpl_ready | output | 1 | Outbound queue has space |
| core_cpl_data | input | 32 | Completion tag |
| core_fw_ready | input | 1 | Core firmware is ready |
| core_doorbell | output | 32 | Current doorbell word |
| irq | output | 1 | Level reply interrupt |
| req_overflow | output | 1 | Sticky flag: a request was dropped on a full queue |

## Verification
The bench builds two copies side by side from the same stimulus. Both use a queue depth of 4 so that the full-queue drop and the stalled completion handshake are reached within a few accesses. One copy keeps the default mask position, bit 3, and the other uses bit 2. This lets every mask write be checked against both bit placements at once: a write of 0x04 must silence only the variant, and a write of 0x08 only the default.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Register offsets the host driver decodes
    localparam logic [ADDR_W-1:0] OFS_DOORBELL = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_ISTAT    = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_IMASK    = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_REQ      = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RPL      = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_READY    = 8'hB0;

    localparam logic [DATA_W-1:0] RPL_EMPTY_WORD = '1;
    localparam logic [DATA_W-1:0] FW_READY_WORD  = 32'hFFFF_0000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DOORBELL,
        SEL_ISTAT,
        SEL_IMASK,
        SEL_REQ,
        SEL_RPL,
        SEL_READY
    } reg_sel_e;

    typedef struct packed {
        logic                 wr;
        logic                 rd;
        reg_sel_e             sel;
        logic [DATA_W-1:0]    wdata;
    } bus_op_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_DOORBELL: return SEL_DOORBELL;
            OFS_ISTAT:    return SEL_ISTAT;
            OFS_IMASK:    return SEL_IMASK;
            OFS_REQ:      return SEL_REQ;
            OFS_RPL:      return SEL_RPL;
            OFS_READY:    return SEL_READY;
            default:      return SEL_NONE;
        endcase
    endfunction

    // Place a single flag at a bit position of a data word
    function automatic logic [DATA_W-1:0] flag_word(input int pos, input logic v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[pos] = v;
        return w;
    endfunction

endpackage

// File: rtl/cqp_fifo.sv
module cqp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [W-1:0]                  push_data,
    input  logic                          pop,
    output logic [W-1:0]                  head,
    output logic                          empty,
    output logic                          full,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign count   = cnt;
    assign head    = mem[rptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

    p_empty_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

    p_push_grows_r1: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/cqp_hostif.sv
module cqp_hostif
    import cqp_pkg::*;
#(
    parameter int MASK_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              req_push,
    output logic [DATA_W-1:0] req_data,
    input  logic              req_full,
    output logic              rpl_pop,
    input  logic              rpl_empty,
    input  logic [DATA_W-1:0] rpl_head,
    input  logic              fw_ready,
    output logic [DATA_W-1:0] doorbell,
    output logic              mask_set,
    output logic              overflow
);
    bus_op_t           op;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        op.wr    = bus_wr;
        op.rd    = bus_rd;
        op.sel   = decode_sel(bus_addr);
        op.wdata = bus_wdata;
    end

    assign req_push = op.wr && (op.sel == SEL_REQ);
    assign req_data = op.wdata;
    assign rpl_pop  = op.rd && (op.sel == SEL_RPL);

    always_comb begin
        case (op.sel)
            SEL_DOORBELL: rd_next = doorbell;
            SEL_ISTAT:    rd_next = flag_word(MASK_BIT, !rpl_empty);
            SEL_IMASK:    rd_next = flag_word(MASK_BIT, mask_set);
            SEL_RPL:      rd_next = rpl_empty ? RPL_EMPTY_WORD : rpl_head;
            SEL_READY:    rd_next = fw_ready ? FW_READY_WORD : '0;
            default:      rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            doorbell  <= '0;
            mask_set  <= 1'b1;
            overflow  <= 1'b0;
        end else begin
            if (op.rd) bus_rdata <= rd_next;
            if (op.wr && op.sel == SEL_DOORBELL) doorbell <= op.wdata;
            if (op.wr && op.sel == SEL_IMASK)    mask_set <= op.wdata[MASK_BIT];
            if (req_push && req_full)            overflow <= 1'b1;
        end
    end

    p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_empty_sentinel_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_RPL && rpl_empty) |=> (bus_rdata == RPL_EMPTY_WORD));

    p_ready_word_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_READY && fw_ready) |=> (bus_rdata == FW_READY_WORD));

endmodule

// File: rtl/cqp_port.sv
module cqp_port
    import cqp_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int MASK_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              core_cmd_valid,
    input  logic              core_cmd_ready,
    output logic [31:0]       core_cmd_data,
    input  logic              core_cpl_valid,
    output logic              core_cpl_ready,
    input  logic [31:0]       core_cpl_data,
    input  logic              core_fw_ready,
    output logic [31:0]       core_doorbell,
    output logic              irq,
    output logic              req_overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              req_push, req_full, req_empty;
    logic [DATA_W-1:0] req_data;
    logic [CNT_W-1:0]  req_count;
    logic              rpl_pop, rpl_full, rpl_empty;
    logic [DATA_W-1:0] rpl_head;
    logic [CNT_W-1:0]  rpl_count;
    logic              mask_set;

    cqp_hostif #(.MASK_BIT(MASK_BIT)) u_host (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_push  (req_push),
        .req_data  (req_data),
        .req_full  (req_full),
        .rpl_pop   (rpl_pop),
        .rpl_empty (rpl_empty),
        .rpl_head  (rpl_head),
        .fw_ready  (core_fw_ready),
        .doorbell  (core_doorbell),
        .mask_set  (mask_set),
        .overflow  (req_overflow)
    );

    cqp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_req_q (
        .clk       (clk),
        .rst       (rst),
        .push      (req_push),
        .push_data (req_data),
        .pop       (core_cmd_ready),
        .head      (core_cmd_data),
        .empty     (req_empty),
        .full      (req_full),
        .count     (req_count)
    );

    cqp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rpl_q (
        .clk       (clk),
        .rst       (rst),
        .push      (core_cpl_valid),
        .push_data (core_cpl_data),
        .pop       (rpl_pop),
        .head      (rpl_head),
        .empty     (rpl_empty),
        .full      (rpl_full),
        .count     (rpl_count)
    );

    assign core_cmd_valid = !req_empty;
    assign core_cpl_ready = !rpl_full;
    assign irq            = !rpl_empty && !mask_set;

    // Last reply taken with no new completion arriving: interrupt must drop
    p_irq_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (rpl_pop && rpl_count == CNT_W'(1) && !core_cpl_valid) |=> !irq);

    p_cmd_count_r1: assert property (@(posedge clk) disable iff (rst)
        core_cmd_valid |-> (req_count != '0));

endmodule

// File: tb/tb_cqp_port.sv
`timescale 1ns/1ps
module tb_cqp_port;
    localparam int QD = 4;
    localparam logic [7:0] A_DB = 8'h20, A_ST = 8'h30, A_MK = 8'h34,
                           A_RQ = 8'h40, A_RP = 8'h44, A_RDY = 8'hB0;

    logic clk = 1'b0;
    logic rst;
    logic [7:0]  addr = '0;
    logic wr = 0, rd = 0, cmd_ready = 0, cpl_valid = 0, fw_ready = 0;
    logic [31:0] wdata = '0, cpl_data = '0;
    logic [31:0] rdata_a, rdata_b, cmd_data_a, cmd_data_b, db_a, db_b;
    logic cmd_valid_a, cmd_valid_b, cpl_ready_a, cpl_ready_b;
    logic irq_a, irq_b, ovf_a, ovf_b;

    int nvec = 0, nfail = 0;
    bit done = 0;

    logic [31:0] inq[$];
    logic [31:0] outq[$];
    bit mask_a = 1, mask_b = 1, ovf_m = 0;

    always #10 clk = ~clk;

    cqp_port #(.DEPTH(QD), .MASK_BIT(3)) dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .core_cmd_valid(cmd_valid_a),
        .core_cmd_ready(cmd_ready), .core_cmd_data(cmd_data_a),
        .core_cpl_valid(cpl_valid), .core_cpl_ready(cpl_ready_a),
        .core_cpl_data(cpl_data), .core_fw_ready(fw_ready),
        .core_doorbell(db_a), .irq(irq_a), .req_overflow(ovf_a));

    cqp_port #(.DEPTH(QD), .MASK_BIT(2)) dut_b (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .core_cmd_valid(cmd_valid_b),
        .core_cmd_ready(cmd_ready), .core_cmd_data(cmd_data_b),
        .core_cpl_valid(cpl_valid), .core_cpl_ready(cpl_ready_b),
        .core_cpl_data(cpl_data), .core_fw_ready(fw_ready),
        .core_doorbell(db_b), .irq(irq_b), .req_overflow(ovf_b));

    function automatic logic [31:0] bitw(int pos, bit v);
        return v ? (32'd1 << pos) : 32'd0;
    endfunction
    function automatic logic exp_irq(bit m);
        return (outq.size() != 0) && !m;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] va, output logic [31:0] vb);
        @(negedge clk); addr = a; rd = 1;
        @(negedge clk); rd = 0; va = rdata_a; vb = rdata_b;
    endtask

    task automatic check_irq(string tag);
        chk({tag, " irq_a"}, 32'(irq_a), 32'(exp_irq(mask_a)));
        chk({tag, " irq_b"}, 32'(irq_b), 32'(exp_irq(mask_b)));
    endtask

    task automatic host_req(logic [31:0] d);
        if (inq.size() < QD) inq.push_back(d); else ovf_m = 1;
        bus_write(A_RQ, d);
        chk("R8 overflow flag", 32'(ovf_a), 32'(ovf_m));
        chk("R8 overflow flag b", 32'(ovf_b), 32'(ovf_m));
    endtask

    task automatic host_reply();
        logic [31:0] e, va, vb;
        e = (outq.size() != 0) ? outq.pop_front() : 32'hFFFF_FFFF;
        bus_read(A_RP, va, vb);
        chk("R2/R3 reply read", va, e);
        chk("R2/R3 reply read b", vb, e);
        check_irq("R6 after reply");
    endtask

    task automatic core_take();
        @(negedge clk);
        chk("R1 cmd valid", 32'(cmd_valid_a), 32'(inq.size() != 0));
        chk("R1 cmd valid b", 32'(cmd_valid_b), 32'(inq.size() != 0));
        if (inq.size() != 0) begin
            chk("R1 cmd order", cmd_data_a, inq[0]);
            chk("R1 cmd order b", cmd_data_b, inq[0]);
            void'(inq.pop_front());
        end
        cmd_ready = 1;
        @(negedge clk); cmd_ready = 0;
    endtask

    task automatic core_give(logic [31:0] d);
        bit rdy;
        @(negedge clk);
        rdy = outq.size() < QD;
        chk("R9 cpl ready", 32'(cpl_ready_a), 32'(rdy));
        chk("R9 cpl ready b", 32'(cpl_ready_b), 32'(rdy));
        cpl_valid = 1; cpl_data = d;
        @(negedge clk); cpl_valid = 0;
        if (rdy) outq.push_back(d);
    endtask

    task automatic set_mask(logic [31:0] v);
        logic [31:0] va, vb;
        bus_write(A_MK, v);
        mask_a = v[3]; mask_b = v[2];
        check_irq("R4 after mask write");
        bus_read(A_MK, va, vb);
        chk("R4 mask readback", va, bitw(3, mask_a));
        chk("R4 mask readback b", vb, bitw(2, mask_b));
    endtask

    task automatic read_status();
        logic [31:0] va, vb;
        bus_read(A_ST, va, vb);
        chk("R5 status", va, bitw(3, outq.size() != 0));
        chk("R5 status b", vb, bitw(2, outq.size() != 0));
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL R10 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] va, vb;
        void'($urandom(32'd20240611));
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R10 reset state
        @(negedge clk);
        chk("R10 irq", 32'(irq_a | irq_b), 0);
        chk("R10 cmd valid", 32'(cmd_valid_a | cmd_valid_b), 0);
        chk("R10 overflow", 32'(ovf_a | ovf_b), 0);
        chk("R10 cpl ready", 32'(cpl_ready_a & cpl_ready_b), 1);
        bus_read(A_MK, va, vb);
        chk("R4 reset mask", va, 32'h8);
        chk("R4 reset mask b", vb, 32'h4);
        read_status();
        host_reply();                      // R3 empty sentinel

        // R7 readiness word
        bus_read(A_RDY, va, vb);
        chk("R7 not ready", va, 0);
        fw_ready = 1;
        bus_read(A_RDY, va, vb);
        chk("R7 ready", va, 32'hFFFF_0000);
        chk("R7 ready b", vb, 32'hFFFF_0000);

        // R11 doorbell
        bus_write(A_DB, 32'hA5A5_0001);
        chk("R11 doorbell out", db_a, 32'hA5A5_0001);
        bus_read(A_DB, va, vb);
        chk("R11 doorbell readback", vb, 32'hA5A5_0001);

        // R1/R8 fill inbound past depth
        for (int i = 0; i < QD + 1; i++) host_req(32'h1000_0000 + 32'(i));
        for (int i = 0; i < QD + 1; i++) core_take();

        // R4/R5/R6 mask and status
        core_give(32'hC0DE_0001);
        core_give(32'hC0DE_0002);
        read_status();
        check_irq("R4 masked at reset");
        set_mask(32'h0);
        set_mask(32'h4);
        set_mask(32'h8);
        set_mask(32'h0);
        host_reply();
        host_reply();                      // R6 drops after last
        host_reply();                      // R3 sentinel again
        read_status();

        // R9 outbound full
        for (int i = 0; i < QD + 1; i++) core_give(32'hBEEF_0000 + 32'(i));
        for (int i = 0; i < QD; i++) host_reply();

        // Constrained random mix
        for (int n = 0; n < 800; n++) begin
            case ($urandom_range(0, 6))
                0, 1: host_req($urandom());
                2:    core_take();
                3:    core_give($urandom());
                4:    host_reply();
                5:    set_mask($urandom_range(0, 15));
                default: read_status();
            endcase
        end

        done = 1;
        summary();
        $finish;
    end
endmodule